// File: doc/BRIEF.md
# DMA Block-Transfer Controller

This block is a single DMA channel that moves a block of words between a device-side queue port and a simple memory port. The processor does not take part in the move. Software sets up three memory-mapped registers: the first memory address, the number of words, and a control/status word. It then sets the start bit. The controller holds a bus request while it works. It moves one word in each cycle in which the grant is high and the device side can accept or supply a word. When the last word has moved it sets a done flag, and it can also raise an interrupt.

The transfer direction comes from a control bit. With the bit set, words are read from memory and pushed into the device queue. With the bit clear, words are popped from the device queue and written to memory. The memory port reads combinationally in the cycle it is enabled. The device queue shows its head word before the pop (show-ahead). The address and count registers track progress, so software can read back the current address and the number of words left.

Top module: `dma_blk_ctrl`

## Requirements
- R1: After reset, the address, count and control/status registers read zero, and bus_req, irq, mem_en, dev_push and dev_pop are low.
- R2: Register select 0 is the memory address and select 1 is the word count. Both can be written while idle and read back, and select 3 reads zero.
- R3: The control/status word (select 2) holds the direction in bit 0, done in bit 1, interrupt enable in bit 30 and the interrupt flag in bit 31. The start bit (bit 2) and all other bits read 0. A write updates only the direction and the enable; the done and flag bits written are ignored.
- R4: A control write with bit 2 set and a nonzero count raises bus_req from the next cycle and clears done and the interrupt flag in that same edge.
- R5: With direction 1, every cycle that has bus_req, bus_gnt and a non-full device reads memory at the current address and pushes that word to the device.
- R6: With direction 0, every cycle that has bus_req, bus_gnt and a non-empty device pops the device head word and writes it to memory at the current address.
- R7: Each word moved increments the address register by one and decrements the count register by one.
- R8: In a cycle with bus_gnt low, or with the device not ready, no word moves: the address and count hold and bus_req stays high.
- R9: The edge that moves the last word drops bus_req and sets done. With the grant held high and the device always ready, an N-word block keeps bus_req high for exactly N cycles.
- R10: Completion sets the interrupt flag only if the enable bit is set, and the irq output always equals the flag.
- R11: A read of the control/status register returns the flag as it stands and clears it at that edge, unless a completion happens in the same cycle.
- R12: A start with a zero count sets done at once without requesting the bus, and sets the flag if the enable written with it is 1.
- R13: Register writes of any select made while a transfer is active are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control/status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read of select 2 clears the flag) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_sel |
| bus_req | output | 1 | Bus request, high while a transfer is active |
| bus_gnt | input | 1 | Bus grant |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | WORD_W | Memory write data |
| mem_rdata | input | WORD_W | Memory read data, valid in the access cycle |
| dev_push | output | 1 | Push a word into the device queue |
| dev_wdata | output | WORD_W | Word pushed to the device |
| dev_full | input | 1 | Device queue cannot accept a word |
| dev_pop | output | 1 | Pop the device queue head |
| dev_rdata | input | WORD_W | Device queue head word (show-ahead) |
| dev_empty | input | 1 | Device queue has no word |
| irq | output | 1 | Interrupt request, equal to status bit 31 |

## Verification
The main function is tried in both directions with three kinds of flow control. The first keeps the grant high and the device always ready, which confirms the exact length of the bus request. The second alternates the grant and lets the queue run empty, which separates stalls caused by the grant from stalls caused by the device. The third raises the full flag while granted, which shows that backpressure from the device stops the move even with the bus owned. Writes made while a transfer is stalled, a zero count, and a restart after an unserviced interrupt separate the done and flag rules from the transfer itself.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
   localparam int unsigned REG_W = 32;

   typedef enum logic [1:0] {
      SEL_ADDR  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   // control/status bit positions
   localparam int unsigned CB_DIR  = 0;
   localparam int unsigned CB_DONE = 1;
   localparam int unsigned CB_GO   = 2;
   localparam int unsigned CB_IE   = 30;
   localparam int unsigned CB_IRQ  = 31;
endpackage

// File: rtl/dma_blk_seq.sv
module dma_blk_seq #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_addr,
   input  logic              ld_cnt,
   input  logic [ADDR_W-1:0] ld_addr_val,
   input  logic [CNT_W-1:0]  ld_cnt_val,
   input  logic              go,
   input  logic              beat,
   output logic [ADDR_W-1:0] addr,
   output logic [CNT_W-1:0]  cnt,
   output logic              active,
   output logic              cnt_zero,
   output logic              complete
);
   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

   assign cnt_zero = (cnt == '0);
   assign complete = beat && (cnt == CNT_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr   <= '0;
         cnt    <= '0;
         active <= 1'b0;
      end else begin
         if (ld_addr) addr <= ld_addr_val;
         else if (beat) addr <= addr + ADDR_ONE;

         if (ld_cnt) cnt <= ld_cnt_val;
         else if (beat) cnt <= cnt - CNT_ONE;

         if (go) active <= 1'b1;
         else if (complete) active <= 1'b0;
      end
   end

   // an active channel always has words left to move
   assert_active_has_words_R7: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> !cnt_zero);

   assert_step_per_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      beat |=> (addr == $past(addr) + ADDR_ONE) && (cnt == $past(cnt) - CNT_ONE));

   assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !beat) |=> $stable(addr) && $stable(cnt) && active);

   assert_last_word_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      complete |=> !active && cnt_zero);
endmodule

// File: rtl/dma_blk_xfer.sv
module dma_blk_xfer #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              dir,
   input  logic [ADDR_W-1:0] addr,
   input  logic              bus_gnt,
   input  logic              dev_full,
   input  logic              dev_empty,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic [WORD_W-1:0] dev_rdata,
   output logic              beat,
   output logic              bus_req,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              dev_push,
   output logic [WORD_W-1:0] dev_wdata,
   output logic              dev_pop
);
   logic side_ready;

   // dir=1: memory -> device, needs room; dir=0: device -> memory, needs data
   assign side_ready = dir ? !dev_full : !dev_empty;
   assign bus_req    = active;
   assign beat       = active && bus_gnt && side_ready;

   assign mem_en    = beat;
   assign mem_we    = beat && !dir;
   assign mem_addr  = addr;
   assign mem_wdata = dev_rdata;
   assign dev_push  = beat && dir;
   assign dev_wdata = mem_rdata;
   assign dev_pop   = beat && !dir;

   assert_access_needs_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> bus_gnt && bus_req);

   assert_push_has_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dev_push |-> !dev_full && mem_en && !mem_we);

   assert_pop_has_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dev_pop |-> !dev_empty && mem_en && mem_we);

   assert_one_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dev_push, dev_pop}));
endmodule

// File: rtl/dma_blk_regs.sv
module dma_blk_regs
   import dma_blk_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              active,
   input  logic              cnt_zero,
   input  logic              complete,
   output logic              ld_addr,
   output logic              ld_cnt,
   output logic              go,
   output logic              dir,
   output logic              irq
);
   logic             ie, done;
   logic             ctrl_wr, zero_go, stat_rd;
   logic [REG_W-1:0] addr_word, cnt_word, ctrl_word;
   logic             unused_wdata;

   assign unused_wdata = ^{reg_wdata[REG_W-1], reg_wdata[CB_IE-1:CB_GO+1], reg_wdata[CB_DONE]};

   // writes land only while idle
   assign ld_addr = reg_wr && !active && (reg_sel == SEL_ADDR);
   assign ld_cnt  = reg_wr && !active && (reg_sel == SEL_COUNT);
   assign ctrl_wr = reg_wr && !active && (reg_sel == SEL_CTRL);
   assign go      = ctrl_wr && reg_wdata[CB_GO] && !cnt_zero;
   assign zero_go = ctrl_wr && reg_wdata[CB_GO] && cnt_zero;
   assign stat_rd = reg_rd && (reg_sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir  <= 1'b0;
         ie   <= 1'b0;
         done <= 1'b0;
         irq  <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            dir <= reg_wdata[CB_DIR];
            ie  <= reg_wdata[CB_IE];
         end
         if (go) done <= 1'b0;
         else if (complete || zero_go) done <= 1'b1;

         if (go) irq <= 1'b0;
         else if ((complete && ie) || (zero_go && reg_wdata[CB_IE])) irq <= 1'b1;
         else if (stat_rd) irq <= 1'b0;
      end
   end

   // readback width adaptation
   generate
      if (ADDR_W < REG_W) begin : g_addr_pad
         assign addr_word = {{(REG_W-ADDR_W){1'b0}}, addr};
      end else begin : g_addr_full
         assign addr_word = addr;
      end
      if (CNT_W < REG_W) begin : g_cnt_pad
         assign cnt_word = {{(REG_W-CNT_W){1'b0}}, cnt};
      end else begin : g_cnt_full
         assign cnt_word = cnt;
      end
   endgenerate

   always_comb begin
      ctrl_word          = '0;
      ctrl_word[CB_DIR]  = dir;
      ctrl_word[CB_DONE] = done;
      ctrl_word[CB_IE]   = ie;
      ctrl_word[CB_IRQ]  = irq;
   end

   always_comb begin
      case (reg_sel)
         SEL_ADDR:  reg_rdata = addr_word;
         SEL_COUNT: reg_rdata = cnt_word;
         SEL_CTRL:  reg_rdata = ctrl_word;
         default:   reg_rdata = '0;
      endcase
   end

   assert_flag_implies_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done);

   assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> !done && !irq && active);

   assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !complete && !reg_wr) |=> !irq);

   assert_zero_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
      zero_go |=> done && !active);

   assert_busy_write_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && active) |=> $stable(dir) && $stable(ie));
endmodule

// File: rtl/dma_blk_ctrl.sv
module dma_blk_ctrl
   import dma_blk_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              dev_push,
   output logic [WORD_W-1:0] dev_wdata,
   input  logic              dev_full,
   output logic              dev_pop,
   input  logic [WORD_W-1:0] dev_rdata,
   input  logic              dev_empty,
   output logic              irq
);
   generate
      if (ADDR_W < 1 || ADDR_W > REG_W) begin : g_bad_addr
         $error("ADDR_W must lie in 1..32");
      end
      if (CNT_W < 1 || CNT_W > REG_W) begin : g_bad_cnt
         $error("CNT_W must lie in 1..32");
      end
      if (WORD_W < 1) begin : g_bad_word
         $error("WORD_W must be positive");
      end
   endgenerate

   logic [ADDR_W-1:0] addr;
   logic [CNT_W-1:0]  cnt;
   logic active, cnt_zero, complete, beat;
   logic ld_addr, ld_cnt, go, dir;

   dma_blk_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .addr(addr), .cnt(cnt), .active(active), .cnt_zero(cnt_zero),
      .complete(complete), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
      .go(go), .dir(dir), .irq(irq)
   );

   dma_blk_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .ld_addr(ld_addr), .ld_cnt(ld_cnt),
      .ld_addr_val(reg_wdata[ADDR_W-1:0]), .ld_cnt_val(reg_wdata[CNT_W-1:0]),
      .go(go), .beat(beat),
      .addr(addr), .cnt(cnt), .active(active),
      .cnt_zero(cnt_zero), .complete(complete)
   );

   dma_blk_xfer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_xfer (
      .clk(clk), .rst_n(rst_n),
      .active(active), .dir(dir), .addr(addr), .bus_gnt(bus_gnt),
      .dev_full(dev_full), .dev_empty(dev_empty),
      .mem_rdata(mem_rdata), .dev_rdata(dev_rdata),
      .beat(beat), .bus_req(bus_req),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .dev_push(dev_push), .dev_wdata(dev_wdata),
      .dev_pop(dev_pop)
   );

   assert_irq_follows_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !bus_req);
endmodule

// File: tb/dma_blk_ctrl_tb.sv
module dma_blk_ctrl_tb;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        bus_req, bus_gnt = 1'b1;
   logic        mem_en, mem_we;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic        dev_push, dev_pop, irq;
   logic [31:0] dev_wdata, dev_rdata;
   logic        dev_full = 1'b0, dev_empty = 1'b0;

   logic [31:0] mem [64];
   logic [31:0] src [64];
   logic [31:0] rx  [64];
   int          src_ptr = 0, rx_n = 0;
   int          checks = 0, fails = 0;
   logic        stress = 1'b0;
   int          tick = 0;
   logic        finished = 1'b0;

   always #2.5 clk = ~clk;

   dma_blk_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .dev_push(dev_push), .dev_wdata(dev_wdata), .dev_full(dev_full),
      .dev_pop(dev_pop), .dev_rdata(dev_rdata), .dev_empty(dev_empty),
      .irq(irq)
   );

   assign mem_rdata = mem[mem_addr[5:0]];
   assign dev_rdata = src[src_ptr[5:0]];

   always @(posedge clk) begin
      if (mem_en && mem_we) mem[mem_addr[5:0]] <= mem_wdata;
      if (dev_push) begin
         rx[rx_n[5:0]] <= dev_wdata;
         rx_n <= rx_n + 1;
      end
      if (dev_pop) src_ptr <= src_ptr + 1;
   end

   // flow-control stress pattern
   always @(negedge clk) begin
      if (stress) begin
         tick = tick + 1;
         bus_gnt = tick[0];
         dev_empty = (tick % 3 == 0);
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] sel, output logic [31:0] d);
      @(negedge clk);
      reg_sel = sel; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (bus_req && n < 500) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check(!bus_req && !irq && !mem_en && !dev_push && !dev_pop, "R1 outputs", {27'd0, bus_req, irq, mem_en, dev_push, dev_pop}, 0);
      reg_read(2'd0, d); check(d == 0, "R1 addr", d, 0);
      reg_read(2'd1, d); check(d == 0, "R1 count", d, 0);
      reg_read(2'd2, d); check(d == 0, "R1 ctrl", d, 0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      reg_write(2'd0, 32'h0000_0010);
      reg_write(2'd1, 32'h0000_0005);
      reg_read(2'd0, d); check(d == 32'h10, "R2 addr readback", d, 32'h10);
      reg_read(2'd1, d); check(d == 32'h5, "R2 count readback", d, 32'h5);
      reg_read(2'd3, d); check(d == 0, "R2 select 3", d, 0);
      reg_write(2'd2, 32'hC000_0003);
      reg_read(2'd2, d); check(d == 32'h4000_0001, "R3 ctrl layout", d, 32'h4000_0001);
      check(!bus_req && !irq, "R3 no start", {30'd0, bus_req, irq}, 0);
   endtask

   task automatic t_mem_to_dev();
      logic [31:0] d;
      int n, base;
      base = rx_n;
      bus_gnt = 1'b1; dev_full = 1'b0;
      reg_write(2'd0, 32'd4);
      reg_write(2'd1, 32'd4);
      reg_write(2'd2, 32'h4000_0005);
      check(bus_req, "R4 bus_req after start", {31'd0, bus_req}, 1);
      wait_idle(n);
      check(n == 4, "R9 request length", n, 4);
      for (int i = 0; i < 4; i++)
         check(rx[base + i] == mem[4 + i], "R5 pushed word", rx[base + i], mem[4 + i]);
      check(rx_n - base == 4, "R5 push count", rx_n - base, 4);
      check(irq, "R10 irq raised", {31'd0, irq}, 1);
      reg_read(2'd0, d); check(d == 8, "R7 final addr", d, 8);
      reg_read(2'd1, d); check(d == 0, "R7 final count", d, 0);
      reg_read(2'd2, d); check(d == 32'hC000_0003, "R11 read shows flag", d, 32'hC000_0003);
      check(!irq, "R11 flag cleared by read", {31'd0, irq}, 0);
      reg_read(2'd2, d); check(d == 32'h4000_0003, "R11 status after clear", d, 32'h4000_0003);
   endtask

   task automatic t_dev_to_mem();
      logic [31:0] d;
      int n, base;
      base = src_ptr;
      bus_gnt = 1'b0; dev_empty = 1'b0;
      reg_write(2'd0, 32'h20);
      reg_write(2'd1, 32'd6);
      reg_write(2'd2, 32'h0000_0004);
      repeat (3) @(negedge clk);
      reg_read(2'd1, d); check(d == 6, "R8 count held without grant", d, 6);
      reg_read(2'd0, d); check(d == 32'h20, "R8 addr held without grant", d, 32'h20);
      check(bus_req, "R8 request held", {31'd0, bus_req}, 1);
      reg_write(2'd1, 32'd99);
      reg_write(2'd0, 32'd0);
      reg_write(2'd2, 32'h4000_0001);
      reg_read(2'd1, d); check(d == 6, "R13 count write ignored", d, 6);
      reg_read(2'd0, d); check(d == 32'h20, "R13 addr write ignored", d, 32'h20);
      reg_read(2'd2, d); check(d == 0, "R13 ctrl write ignored", d, 0);
      tick = 0; stress = 1'b1;
      wait_idle(n);
      stress = 1'b0; bus_gnt = 1'b1; dev_empty = 1'b0;
      check(n > 6, "R8 stalls lengthen transfer", n, 7);
      for (int i = 0; i < 6; i++)
         check(mem[32 + i] == src[base + i], "R6 written word", mem[32 + i], src[base + i]);
      check(src_ptr - base == 6, "R6 pop count", src_ptr - base, 6);
      check(!irq, "R10 no irq when disabled", {31'd0, irq}, 0);
      reg_read(2'd2, d); check(d == 32'h2, "R10 done only", d, 32'h2);
      reg_read(2'd0, d); check(d == 32'h26, "R7 addr after dev block", d, 32'h26);
   endtask

   task automatic t_zero_and_restart();
      logic [31:0] d;
      int n, base;
      reg_write(2'd1, 32'd0);
      reg_write(2'd2, 32'h4000_0004);
      check(!bus_req, "R12 no request", {31'd0, bus_req}, 0);
      check(irq, "R12 irq on zero count", {31'd0, irq}, 1);
      base = rx_n;
      bus_gnt = 1'b1; dev_full = 1'b1;
      reg_write(2'd0, 32'h30);
      reg_write(2'd1, 32'd2);
      reg_write(2'd2, 32'h4000_0005);
      check(!irq && bus_req, "R4 restart clears flag", {30'd0, irq, bus_req}, 1);
      repeat (2) @(negedge clk);
      reg_read(2'd1, d); check(d == 2, "R5 full device stalls", d, 2);
      reg_read(2'd2, d); check(d == 32'h4000_0001, "R4 done cleared", d, 32'h4000_0001);
      dev_full = 1'b0;
      wait_idle(n);
      check(irq, "R10 irq at end", {31'd0, irq}, 1);
      check(rx[base] == mem[48] && rx[base + 1] == mem[49], "R5 restart words", rx[base + 1], mem[49]);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         mem[i] = 32'hA000_0000 + i;
         src[i] = 32'h5000_0000 + i;
         rx[i]  = '0;
      end
      repeat (3) @(negedge clk);
      t_reset_pre();
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_mem_to_dev();
      t_dev_to_mem();
      t_zero_and_restart();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   task automatic t_reset_pre();
      check(!bus_req && !irq, "R1 in reset", {30'd0, bus_req, irq}, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule